// File: doc/BRIEF.md
# Conditional Branch Resolver with Likely-Annul

This block decides, in a single combinational pass, the outcome of a conditional branch in a core that has a branch delay slot. It covers two families. One tests the sign of a general register value. The other tests the floating-point compare flag. For each branch it produces four things: the target address, a taken flag, a flag that cancels the delay-slot instruction, and a request to write the return address into the link register.

The decode stage presents the current PC, the 16-bit offset field, the 5-bit selector field and a group select. The register value and the floating-point flag arrive from the operand path. The outputs settle within the same cycle. Fetch redirection, register-indirect jumps and exceptions belong to the surrounding pipeline.

Top module: `brResolver`

## Requirements
- R1: `tgtAddr` always equals `curPc + 4 + (sign-extended brOffset << 2)`, modulo 2^ADDR_W, for every selector and group.
- R2: In the register group (`fpGroup` = 0), a recognised code with selector bit 0 clear is a "less than zero" test. `brTaken` is 1 exactly when `srcVal` is negative as a signed number.
- R3: In the register group, a recognised code with selector bit 0 set is a "zero or above" test. `brTaken` is 1 exactly when the top bit of `srcVal` is 0.
- R4: In the register group, codes 0x10–0x13 (selector bit 4 set) raise `linkWe` whether or not the branch is taken. `linkIdx` then equals 31 and `linkVal` equals `curPc + 8`.
- R5: Codes with selector bit 1 set are the likely forms (0x02, 0x03, 0x12, 0x13 in the register group). They raise `slotAnnul` exactly when not taken. Codes with bit 1 clear never raise `slotAnnul`.
- R6: In the floating-point group (`fpGroup` = 1), codes 0x00 and 0x02 are taken when `fpCond` is 0. Codes 0x01 and 0x03 are taken when `fpCond` is 1.
- R7: In the floating-point group, codes 0x02 and 0x03 raise `slotAnnul` exactly when not taken. Codes 0x00 and 0x01 never do.
- R8: Any unrecognised code gives `brTaken` = 0, `slotAnnul` = 0 and `linkWe` = 0. In the register group these are codes with bit 2 or bit 3 set. In the floating-point group they are any code above 0x03.
- R9: `brTaken` and `slotAnnul` are never 1 together.
- R10: Register-group codes 0x00–0x03 and all floating-point group codes leave `linkWe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| curPc | input | 32 | Address of the branch instruction |
| brOffset | input | 16 | Signed word offset from the instruction |
| condSel | input | 5 | Selector field naming the branch form |
| fpGroup | input | 1 | 1 selects the floating-point flag family, 0 the register sign family |
| srcVal | input | 32 | Source register value tested for sign |
| fpCond | input | 1 | Floating-point compare flag |
| tgtAddr | output | 32 | Branch target address |
| brTaken | output | 1 | Branch is taken |
| slotAnnul | output | 1 | Cancel the delay-slot instruction |
| linkWe | output | 1 | Write the return address to the link register |
| linkIdx | output | 5 | Link register index (31) |
| linkVal | output | 32 | Return address, curPc + 8 |

## Verification
The assertions assume only that the inputs hold stable, known values at the moment they are evaluated. They place no legality limits on the selector or the group, so unrecognised codes are checked exactly like valid ones. The stimulus changes inputs only right after a clock edge and compares results half a period later.

Random selectors are drawn from all 32 codes in both groups. Register values are biased toward zero, -1 and both sign extremes. Offsets and PCs include the extreme negative offset and wrap-around near the top of the address space, so the adder and the sign tests see their boundaries.

// File: rtl/brResolverPkg.sv
`timescale 1ns/1ps
package brResolverPkg;

  // Strobes the decoder hands to the datapath
  typedef struct packed {
    logic known;    // recognised selector in the chosen group
    logic sense;    // 1: taken on gez / flag set, 0: taken on ltz / flag clear
    logic useFlag;  // test fpCond instead of the register sign
    logic likely;   // cancel delay slot when not taken
    logic link;     // write return address
  } brStrobe_t;

  // Selector bit positions the decode relies on
  localparam int SENSE_BIT  = 0;
  localparam int LIKELY_BIT = 1;
  localparam int LINK_BIT   = 4;

endpackage

// File: rtl/brCtrl.sv
`timescale 1ns/1ps
module brCtrl
  import brResolverPkg::*;
#(
  parameter int SEL_W = 5
) (
  input  logic [SEL_W-1:0] condSel,
  input  logic             fpGroup,
  output brStrobe_t        strobe
);

  // Register group: bits 3:2 must be zero, bit 4 chooses link.
  // Flag group: bits 4:2 must be zero.
  logic midZero;
  logic topBit;
  logic regKnown;
  logic flagKnown;

  always_comb begin
    midZero   = (condSel[3:2] == 2'b00);
    topBit    = condSel[LINK_BIT];
    regKnown  = !fpGroup && midZero;
    flagKnown = fpGroup && midZero && !topBit;

    strobe.known   = regKnown || flagKnown;
    strobe.sense   = condSel[SENSE_BIT];
    strobe.useFlag = fpGroup;
    strobe.likely  = condSel[LIKELY_BIT];
    strobe.link    = regKnown && topBit;
  end

endmodule

// File: rtl/brData.sv
`timescale 1ns/1ps
module brData
  import brResolverPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter int LINK_REG  = 31
) (
  input  logic [ADDR_W-1:0]    curPc,
  input  logic [OFF_W-1:0]     brOffset,
  input  logic [DATA_W-1:0]    srcVal,
  input  logic                 fpCond,
  input  brStrobe_t            strobe,
  output logic [ADDR_W-1:0]    tgtAddr,
  output logic                 brTaken,
  output logic                 slotAnnul,
  output logic                 linkWe,
  output logic [REG_IDX_W-1:0] linkIdx,
  output logic [ADDR_W-1:0]    linkVal
);

  localparam int EXT_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] SLOT_SKIP  = ADDR_W'(8);

  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] seqPc;
  logic              isNeg;
  logic              condBit;
  logic              condMet;

  // Address path
  always_comb begin
    offExt  = {{EXT_W{brOffset[OFF_W-1]}}, brOffset} << 2;
    seqPc   = curPc + INSN_BYTES;
    tgtAddr = seqPc + offExt;
    linkVal = curPc + SLOT_SKIP;
    linkIdx = REG_IDX_W'(LINK_REG);
  end

  // Condition path
  always_comb begin
    isNeg   = srcVal[DATA_W-1];
    condBit = strobe.useFlag ? fpCond : !isNeg;
    // sense=1: take when condBit set; sense=0: take when clear
    condMet = strobe.sense ? condBit : !condBit;

    brTaken   = strobe.known && condMet;
    slotAnnul = strobe.known && strobe.likely && !condMet;
    linkWe    = strobe.link;
  end

endmodule

// File: rtl/brResolver.sv
`timescale 1ns/1ps
module brResolver
  import brResolverPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 5,
  parameter int REG_IDX_W = 5,
  parameter int LINK_REG  = 31
) (
  input  logic [ADDR_W-1:0]    curPc,
  input  logic [OFF_W-1:0]     brOffset,
  input  logic [SEL_W-1:0]     condSel,
  input  logic                 fpGroup,
  input  logic [DATA_W-1:0]    srcVal,
  input  logic                 fpCond,
  output logic [ADDR_W-1:0]    tgtAddr,
  output logic                 brTaken,
  output logic                 slotAnnul,
  output logic                 linkWe,
  output logic [REG_IDX_W-1:0] linkIdx,
  output logic [ADDR_W-1:0]    linkVal
);

  brStrobe_t strobe;

  brCtrl #(.SEL_W(SEL_W)) u_ctrl (
    .condSel (condSel),
    .fpGroup (fpGroup),
    .strobe  (strobe)
  );

  brData #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .DATA_W    (DATA_W),
    .REG_IDX_W (REG_IDX_W),
    .LINK_REG  (LINK_REG)
  ) u_data (
    .curPc     (curPc),
    .brOffset  (brOffset),
    .srcVal    (srcVal),
    .fpCond    (fpCond),
    .strobe    (strobe),
    .tgtAddr   (tgtAddr),
    .brTaken   (brTaken),
    .slotAnnul (slotAnnul),
    .linkWe    (linkWe),
    .linkIdx   (linkIdx),
    .linkVal   (linkVal)
  );

endmodule

// File: rtl/brResolverChk.sv
`timescale 1ns/1ps
module brResolverChk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 5,
  parameter int REG_IDX_W = 5,
  parameter int LINK_REG  = 31
) (
  input logic [ADDR_W-1:0]    curPc,
  input logic [SEL_W-1:0]     condSel,
  input logic                 fpGroup,
  input logic [DATA_W-1:0]    srcVal,
  input logic                 fpCond,
  input logic                 brTaken,
  input logic                 slotAnnul,
  input logic                 linkWe,
  input logic [REG_IDX_W-1:0] linkIdx,
  input logic [ADDR_W-1:0]    linkVal
);

  logic regOk;
  logic flagOk;

  always_comb begin
    regOk  = !fpGroup && (condSel[3:2] == 2'b00);
    flagOk = fpGroup && (condSel[4:2] == 3'b000);

    a_r9_exclusive: assert (!(brTaken && slotAnnul))
      else $error("R9 taken and annul both high");

    a_r8_unknown_quiet: assert ((regOk || flagOk) || (!brTaken && !slotAnnul && !linkWe))
      else $error("R8 unrecognised code produced activity");

    a_r4_link_target: assert (!linkWe ||
        (linkIdx == REG_IDX_W'(LINK_REG) && linkVal == curPc + ADDR_W'(8)))
      else $error("R4 link index or value wrong");

    a_r10_no_link: assert (!(fpGroup || !condSel[4]) || !linkWe)
      else $error("R10 link on non-link form");

    a_r5_plain_no_annul: assert (condSel[1] || !slotAnnul)
      else $error("R5 non-likely form annulled");

    a_r2_ltz_sense: assert (!(regOk && !condSel[0]) || (brTaken == srcVal[DATA_W-1]))
      else $error("R2 ltz decision wrong");

    a_r6_flag_sense: assert (!flagOk || (brTaken == (condSel[0] ? fpCond : !fpCond)))
      else $error("R6 flag decision wrong");
  end

endmodule

bind brResolver brResolverChk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .SEL_W     (SEL_W),
  .REG_IDX_W (REG_IDX_W),
  .LINK_REG  (LINK_REG)
) u_chk (
  .curPc     (curPc),
  .condSel   (condSel),
  .fpGroup   (fpGroup),
  .srcVal    (srcVal),
  .fpCond    (fpCond),
  .brTaken   (brTaken),
  .slotAnnul (slotAnnul),
  .linkWe    (linkWe),
  .linkIdx   (linkIdx),
  .linkVal   (linkVal)
);

// File: tb/brResolver_tb.sv
`timescale 1ns/1ps
module brResolver_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] curPc = '0;
  logic [15:0] brOffset = '0;
  logic [4:0]  condSel = '0;
  logic        fpGroup = 1'b0;
  logic [31:0] srcVal = '0;
  logic        fpCond = 1'b0;
  logic [31:0] tgtAddr;
  logic        brTaken;
  logic        slotAnnul;
  logic        linkWe;
  logic [4:0]  linkIdx;
  logic [31:0] linkVal;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  brResolver u_dut (
    .curPc(curPc), .brOffset(brOffset), .condSel(condSel), .fpGroup(fpGroup),
    .srcVal(srcVal), .fpCond(fpCond), .tgtAddr(tgtAddr), .brTaken(brTaken),
    .slotAnnul(slotAnnul), .linkWe(linkWe), .linkIdx(linkIdx), .linkVal(linkVal)
  );

  function automatic bit expKnown(bit fp, logic [4:0] s);
    return fp ? (s[4:2] == 3'b000) : (s[3:2] == 2'b00);
  endfunction

  function automatic bit expCond(bit fp, logic [4:0] s, logic [31:0] v, bit f);
    if (fp) return s[0] ? f : !f;
    return s[0] ? ($signed(v) >= 0) : ($signed(v) < 0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s sel=%h fp=%0b src=%h pc=%h off=%h : actual %h expected %h",
               req, condSel, fpGroup, srcVal, curPc, brOffset, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] pc, logic [15:0] off, logic [4:0] s,
                       bit fp, logic [31:0] v, bit f);
    bit kn, cm, eTaken, eAnnul, eLink;
    logic [31:0] eTgt;
    string tTag, aTag, lTag;
    @(posedge clk);
    #1;
    curPc = pc; brOffset = off; condSel = s; fpGroup = fp; srcVal = v; fpCond = f;
    kn     = expKnown(fp, s);
    cm     = expCond(fp, s, v, f);
    eTaken = kn && cm;
    eAnnul = kn && s[1] && !cm;
    eLink  = kn && !fp && s[4];
    eTgt   = pc + 32'd4 + ({{16{off[15]}}, off} << 2);
    tTag = !kn ? "R8" : (fp ? "R6" : (s[0] ? "R3" : "R2"));
    aTag = !kn ? "R8" : (fp ? "R7" : "R5");
    lTag = !kn ? "R8" : (eLink ? "R4" : "R10");
    @(negedge clk);
    chk("R1", tgtAddr, eTgt);
    chk(tTag, 32'(brTaken), 32'(eTaken));
    chk(aTag, 32'(slotAnnul), 32'(eAnnul));
    chk(lTag, 32'(linkWe), 32'(eLink));
    chk("R9", 32'(brTaken && slotAnnul), 32'd0);
    if (eLink) begin
      chk("R4", 32'(linkIdx), 32'd31);
      chk("R4", linkVal, pc + 32'd8);
    end
  endtask

  function automatic logic [31:0] pickVal(int unsigned r);
    case (r % 8)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-time idle inputs: bltz on zero is not taken, target is 4
    @(negedge clk);
    chk("R1", tgtAddr, 32'd4);
    chk("R2", 32'(brTaken), 32'd0);
    chk("R5", 32'(slotAnnul), 32'd0);
    chk("R10", 32'(linkWe), 32'd0);

    // directed corners
    apply(32'h0000_1000, 16'h8000, 5'h00, 1'b0, 32'h8000_0000, 1'b0); // R2 most negative, max back offset
    apply(32'h0000_1000, 16'h7FFF, 5'h01, 1'b0, 32'h0000_0000, 1'b0); // R3 zero is taken
    apply(32'hFFFF_FFFC, 16'h0001, 5'h02, 1'b0, 32'h0000_0001, 1'b0); // R5 likely not taken, R1 wrap
    apply(32'h0040_0000, 16'hFFFF, 5'h03, 1'b0, 32'hFFFF_FFFF, 1'b0); // R5 bgezl annul
    apply(32'h0040_0010, 16'h0004, 5'h10, 1'b0, 32'h0000_0005, 1'b0); // R4 link when not taken
    apply(32'hFFFF_FFF8, 16'h0004, 5'h13, 1'b0, 32'h8000_0000, 1'b0); // R4 link wrap, annul
    apply(32'h0000_2000, 16'h0010, 5'h00, 1'b1, 32'h0, 1'b0);         // R6 f taken
    apply(32'h0000_2000, 16'h0010, 5'h01, 1'b1, 32'h0, 1'b0);         // R6 t not taken
    apply(32'h0000_2000, 16'h0010, 5'h02, 1'b1, 32'h0, 1'b1);         // R7 fl annul
    apply(32'h0000_2000, 16'h0010, 5'h03, 1'b1, 32'h0, 1'b1);         // R7 tl taken
    apply(32'h0000_2000, 16'h0010, 5'h12, 1'b1, 32'h0, 1'b1);         // R8 link code in flag group
    apply(32'h0000_2000, 16'h0010, 5'h06, 1'b0, 32'h8000_0000, 1'b0); // R8 register group gap
    apply(32'h0000_2000, 16'h0010, 5'h1F, 1'b0, 32'h0, 1'b1);         // R8

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom();
      logic [4:0] s;
      case (r % 4)
        0: s = 5'($urandom_range(0, 3));
        1: s = 5'h10 | 5'($urandom_range(0, 3));
        default: s = 5'($urandom());
      endcase
      apply($urandom(), 16'($urandom()), s, bit'($urandom()), pickVal($urandom()), bit'($urandom()));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule